// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two predictors run side by side. The first is a bimodal table of 2-bit saturating counters, indexed by the low bits of the branch PC. The second is a table of the same kind, indexed by a global history of recent branch outcomes XORed with the same PC bits. A third table, also indexed by PC, holds a 2-bit chooser counter for each entry. It records which of the two predictors has been right more often for that branch, and the final guess comes from that predictor.

The front end presents a PC on the predict port. One cycle later the block returns the final direction, both component bits and the hashed index it used. The pipeline keeps those values with the branch. When the branch resolves, the pipeline sends them back on the update port together with the real outcome. The block then trains both component tables, adjusts the chooser if the two components disagreed, and shifts the outcome into the history. The ports carry only the low `IDX_W` bits of the PC, because these are the only bits the block uses.

Top module: `tourney_bp`

## Requirements
- R1: Every counter steps up by one on a taken outcome and down by one on a not-taken outcome. It never goes below 0 or above 3, and its most significant bit is the predicted direction (1 = taken).
- R2: During and after reset, `pred_out_valid` is 0. Both component tables hold 3 in every entry, every chooser holds 2 and the history register holds 0. The first prediction after reset is therefore taken, and its hashed index equals the PC bits.
- R3: When `pred_valid` is 1 at a clock edge, `pred_out_valid` is 1 after that edge and the prediction outputs show the result for `pred_pc`. When `pred_valid` is 0 at an edge, `pred_out_valid` is 0 after it.
- R4: The global component is read at `pred_gidx = history XOR pred_pc`, and that index is returned on `pred_gidx`. `pred_bim` is the MSB of the bimodal entry at `pred_pc`.
- R5: On each update the history shifts left by one bit, the oldest bit is dropped and `upd_taken` enters bit 0.
- R6: `pred_taken` equals `pred_gsh` when the MSB of the chooser entry at `pred_pc` is 1, and equals `pred_bim` when it is 0.
- R7: The chooser entry at `upd_pc` changes only when `upd_bim` and `upd_gsh` differ. It steps up by one (saturating) when `upd_gsh` matched `upd_taken`, and steps down by one when `upd_bim` matched it.
- R8: Every update trains both the bimodal entry at `upd_pc` and the global entry at `upd_gidx` toward `upd_taken`, whichever component was chosen.
- R9: When a predict and an update happen in the same cycle, the prediction uses the table contents and the history as they were before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| pred_valid | input | 1 | Request a prediction this cycle |
| pred_pc | input | IDX_W | Low PC bits of the branch being predicted |
| pred_out_valid | output | 1 | Prediction outputs are valid this cycle |
| pred_taken | output | 1 | Final predicted direction |
| pred_bim | output | 1 | Bimodal component direction |
| pred_gsh | output | 1 | Global-history component direction |
| pred_gidx | output | IDX_W | Hashed index used for the global component |
| upd_valid | input | 1 | A branch has resolved this cycle |
| upd_pc | input | IDX_W | Low PC bits of the resolved branch |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| upd_bim | input | 1 | Bimodal direction captured at predict time |
| upd_gsh | input | 1 | Global direction captured at predict time |
| upd_gidx | input | IDX_W | Hashed index captured at predict time |

## Verification
A lookup and a training write can fall in the same cycle, and they can touch the same entry and depend on the history that the update is shifting. The bench sets this up on purpose. First it trains one PC down to a known count. Then in a single cycle it predicts and updates that same PC with the opposite outcome. The prediction must show the old counter and the old history. The next prediction must show the new ones. A long random phase also issues predicts and updates together. On every cycle a behavioural model compares the outputs, and that model always reads the tables before it applies the same-cycle update.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_MAX = 2'b11;
  localparam ctr2_t CTR_MIN = 2'b00;
  localparam ctr2_t CTR_STRONG_T = 2'b11;
  localparam ctr2_t CTR_WEAK_T = 2'b10;

  // Saturating step toward the given direction.
  function automatic ctr2_t sat_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else    r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int    IDX_W   = 8,
  parameter ctr2_t RST_VAL = CTR_STRONG_T
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];
  ctr2_t wr_val;
  logic  rd_msb_nxt;

  // Next-state: one entry per cycle, read of pre-write contents.
  always_comb begin
    wr_val     = sat_step(mem[wr_idx], wr_up);
    rd_msb_nxt = rd_en ? mem[rd_idx][1] : rd_msb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_msb <= RST_VAL[1];
    else        rd_msb <= rd_msb_nxt;
  end

  // R1: a full counter stays full on a taken write
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && mem[wr_idx] == CTR_MAX) |=> mem[$past(wr_idx)] == CTR_MAX);

  // R1: an empty counter stays empty on a not-taken write
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && mem[wr_idx] == CTR_MIN) |=> mem[$past(wr_idx)] == CTR_MIN);
endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_nxt;

  generate
    if (HIST_W == 1) begin : g_one
      always_comb hist_nxt = shift_en ? outcome : hist;
    end else begin : g_many
      always_comb hist_nxt = shift_en ? {hist[HIST_W-2:0], outcome} : hist;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= hist_nxt;
  end

  // R5: newest outcome lands in bit 0
  a_r5_newest_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist[0] == $past(outcome));

  // R5: history is held between updates
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import bp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pred_valid,
  input  logic [IDX_W-1:0] pred_pc,
  output logic             pred_out_valid,
  output logic             pred_taken,
  output logic             pred_bim,
  output logic             pred_gsh,
  output logic [IDX_W-1:0] pred_gidx,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_pc,
  input  logic             upd_taken,
  input  logic             upd_bim,
  input  logic             upd_gsh,
  input  logic [IDX_W-1:0] upd_gidx
);
  logic [IDX_W-1:0] hist;
  logic [IDX_W-1:0] hash_idx;
  logic [IDX_W-1:0] gidx_nxt;
  logic             vld_nxt;
  logic             sel_msb;
  logic             sel_wr_en;
  logic             sel_up;

  // Hash and chooser training decisions.
  always_comb begin
    hash_idx  = hist ^ pred_pc;
    gidx_nxt  = pred_valid ? hash_idx : pred_gidx;
    vld_nxt   = pred_valid;
    sel_wr_en = upd_valid && (upd_bim != upd_gsh);
    sel_up    = (upd_gsh == upd_taken);
  end

  bp_ghist #(.HIST_W(IDX_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_valid), .outcome(upd_taken), .hist(hist)
  );

  bp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_STRONG_T)) u_bim (
    .clk(clk), .rst_n(rst_n),
    .rd_en(pred_valid), .rd_idx(pred_pc), .rd_msb(pred_bim),
    .wr_en(upd_valid), .wr_idx(upd_pc), .wr_up(upd_taken)
  );

  bp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_STRONG_T)) u_gsh (
    .clk(clk), .rst_n(rst_n),
    .rd_en(pred_valid), .rd_idx(hash_idx), .rd_msb(pred_gsh),
    .wr_en(upd_valid), .wr_idx(upd_gidx), .wr_up(upd_taken)
  );

  bp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_T)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .rd_en(pred_valid), .rd_idx(pred_pc), .rd_msb(sel_msb),
    .wr_en(sel_wr_en), .wr_idx(upd_pc), .wr_up(sel_up)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_out_valid <= 1'b0;
      pred_gidx      <= '0;
    end else begin
      pred_out_valid <= vld_nxt;
      pred_gidx      <= gidx_nxt;
    end
  end

  always_comb pred_taken = sel_msb ? pred_gsh : pred_bim;

  // R3: a request yields valid outputs one cycle later
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |=> pred_out_valid);

  // R3: no request, no valid output
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |=> !pred_out_valid);

  // R6: when both components agree the chooser is irrelevant
  a_r6_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_out_valid && pred_bim == pred_gsh) |-> pred_taken == pred_bim);

  // R4: returned index reflects the request's PC XOR the pre-edge history
  a_r4_hash: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |=> pred_gidx == ($past(hist) ^ $past(pred_pc)));
endmodule

// File: tb/sim_tourney_bp.sv
module sim_tourney_bp;
  localparam int IDX_W = 8;
  localparam int DEPTH = 1 << IDX_W;
  localparam int MASK  = DEPTH - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_valid = 1'b0;
  logic [IDX_W-1:0] pred_pc = '0;
  logic pred_out_valid, pred_taken, pred_bim, pred_gsh;
  logic [IDX_W-1:0] pred_gidx;
  logic upd_valid = 1'b0;
  logic [IDX_W-1:0] upd_pc = '0;
  logic upd_taken = 1'b0, upd_bim = 1'b0, upd_gsh = 1'b0;
  logic [IDX_W-1:0] upd_gidx = '0;

  always #5 clk = ~clk;

  tourney_bp #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_out_valid(pred_out_valid), .pred_taken(pred_taken),
    .pred_bim(pred_bim), .pred_gsh(pred_gsh), .pred_gidx(pred_gidx),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_bim(upd_bim), .upd_gsh(upd_gsh), .upd_gidx(upd_gidx)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  int m_bim [DEPTH];
  int m_gsh [DEPTH];
  int m_sel [DEPTH];
  int m_hist;
  int e_valid, e_taken, e_bim, e_gsh, e_gidx;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(input int c, input bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_bim[i] = 3; m_gsh[i] = 3; m_sel[i] = 2;
    end
    m_hist = 0; e_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pred_valid = 1'b0; upd_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    chk("R2 valid low in reset", int'(pred_out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 valid low after reset", int'(pred_out_valid), 0);
  endtask

  // One cycle: drive, model at the edge (read before write, R9), compare.
  task automatic step(input bit pv, input int pc, input bit uv, input int upc,
                      input bit ut, input bit ub, input bit ug, input int ugi);
    int g;
    pred_valid = pv; pred_pc = pc[IDX_W-1:0];
    upd_valid = uv; upd_pc = upc[IDX_W-1:0]; upd_taken = ut;
    upd_bim = ub; upd_gsh = ug; upd_gidx = ugi[IDX_W-1:0];
    @(posedge clk);
    e_valid = pv;
    if (pv) begin
      g = (m_hist ^ pc) & MASK;
      e_bim = m_bim[pc & MASK] >> 1;
      e_gsh = m_gsh[g] >> 1;
      e_gidx = g;
      e_taken = (m_sel[pc & MASK] >> 1) ? e_gsh : e_bim;
    end
    if (uv) begin
      m_bim[upc & MASK] = sat(m_bim[upc & MASK], ut);
      m_gsh[ugi & MASK] = sat(m_gsh[ugi & MASK], ut);
      if (ub != ug) m_sel[upc & MASK] = sat(m_sel[upc & MASK], ug == ut);
      m_hist = ((m_hist << 1) | int'(ut)) & MASK;
    end
    @(negedge clk);
    pred_valid = 1'b0; upd_valid = 1'b0;
    chk("R3 out valid", int'(pred_out_valid), e_valid);
    if (e_valid) begin
      chk("R1 R8 bimodal bit", int'(pred_bim), e_bim);
      chk("R8 global bit", int'(pred_gsh), e_gsh);
      chk("R4 hashed index", int'(pred_gidx), e_gidx);
      chk("R6 R7 final direction", int'(pred_taken), e_taken);
    end
  endtask

  task automatic upd(input int upc, input bit ut, input bit ub, input bit ug, input int ugi);
    step(1'b0, 0, 1'b1, upc, ut, ub, ug, ugi);
  endtask

  task automatic pred(input int pc);
    step(1'b1, pc, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();

    // R2: reset contents give a taken guess at an unhashed index
    pred(5);
    chk("R2 first guess taken", int'(pred_taken), 1);
    chk("R2 gsh bit", int'(pred_gsh), 1);
    chk("R2 index equals pc", int'(pred_gidx), 5);

    // R1: drive a counter to the floor and back
    for (int i = 0; i < 5; i++) upd(7, 1'b0, 1'b1, 1'b1, 7);
    pred(7);
    chk("R1 floor not-taken", int'(pred_bim), 0);
    upd(7, 1'b1, 1'b0, 1'b0, 7);
    pred(7);
    chk("R1 count one still not-taken", int'(pred_bim), 0);
    upd(7, 1'b1, 1'b0, 1'b0, 7);
    pred(7);
    chk("R1 count two taken", int'(pred_bim), 1);
    // R5: history is now ...011, so 7 hashes to 4
    chk("R5 shifted history", int'(pred_gidx), 4);

    // R7: chooser moves to bimodal after bimodal alone was right
    do_reset();
    upd(100, 1'b0, 1'b1, 1'b1, 2);
    upd(100, 1'b0, 1'b1, 1'b1, 2);
    upd(3, 1'b1, 1'b1, 1'b0, 50);
    pred(3);
    chk("R7 chooser now bimodal", int'(pred_taken), 1);
    chk("R7 global disagrees", int'(pred_gsh), 0);

    // R9: same-cycle predict and update on one branch
    do_reset();
    upd(9, 1'b0, 1'b1, 1'b1, 9);
    upd(9, 1'b0, 1'b1, 1'b1, 9);
    step(1'b1, 9, 1'b1, 9, 1'b1, 1'b0, 1'b0, 9);
    chk("R9 old counter seen", int'(pred_bim), 0);
    chk("R9 old history seen", int'(pred_gidx), 9);
    pred(9);
    chk("R9 new counter seen", int'(pred_bim), 1);
    chk("R9 new history seen", int'(pred_gidx), 8);

    // Mixed traffic, predicts and updates overlapping
    for (int i = 0; i < 3000; i++) begin
      int pc, upc;
      pc  = $urandom_range(0, 15);
      upc = $urandom_range(0, 15);
      step(1'($urandom_range(0, 1)), pc, 1'($urandom_range(0, 1)), upc,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 15));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule